// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block sits between a host write bus and the internal operation engine of a block-erasable flash array. Each rising edge of the host write enable delivers one command byte and a block index. The decoder turns those bytes into a read-path selection (array, identifier, query or status), into start requests for block erase, chip erase, program and lock-bit updates, and into a ready-pin mode setting. Some commands take one cycle. Others take two: a setup byte followed by a confirm byte or by program data.

The decoder also keeps the suspend state. An erase can be suspended, a program can be started inside that erase suspend, and that program can itself be suspended. Resume always acts on the innermost suspended operation. Each start request is checked against the programming-supply flag, the per-block lock image and the protect pin. A failed check sets an error flag in the status byte, and no start request is issued.

The operation engine is modelled by two signals: a one-cycle start pulse that carries kind, block, data and block mask, and a `done_i` pulse that comes back when the running operation ends.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, and after `rst_ni` is pulled low at any point (which aborts a running or suspended operation), the block has the following state: `rd_sel_o`=0 (array), `status_o`=80h, `hold_o`=0, `lock_o`=0, `sts_mode_o`=0 and `op_start_o`=0. The status bits are: 7 ready, 6 erase suspended, 5 erase error, 4 program error, 3 supply low, 2 program suspended, 1 lock violation, 0 always zero.
- R2: When idle, the following single-cycle bytes set `rd_sel_o`: FFh sets 0 (array), 90h sets 1 (identifier), 98h sets 2 (query) and 70h sets 3 (status). Any undefined byte acts as FFh. A write enable that is held high delivers only one command.
- R3: The sequence 20h then D0h with block b starts a block erase. One cycle after the confirm edge, `op_start_o` pulses with `op_kind_o`=0, `op_blk_o`=b and `op_mask_o` one-hot at b. From then on `rd_sel_o`=3 and status bit 7 is 0 until `done_i`.
- R4: The sequence 40h or 10h, followed by a data byte, starts a program with `op_kind_o`=2. The pulse carries the data on `op_data_o` and the block on `op_blk_o`.
- R5: A second cycle that does not match the expected byte sets status bits 5 and 4, and no start is issued. The expected byte is D0h after 20h or 30h, 01h or D0h after 60h, and 00h to 03h after B8h.
- R6: The sequence 60h then 01h starts a lock set (`op_kind_o`=3), and `lock_o[b]` is set on `done_i`. The sequence 60h then D0h starts a clear of all lock bits (`op_kind_o`=4), and `lock_o` becomes zero on `done_i`. The clear needs `wp_i` high; if `wp_i` is low it sets bits 1 and 5 and issues no start.
- R7: An erase or program of a locked block while `wp_i` is low sets bit 1 together with the error bit of the operation (5 for erase, 4 for program), and issues no start. With `wp_i` high, the operation starts.
- R8: If `vpp_ok_i` is low at the confirm cycle, bit 3 is set together with the error bit of the operation: 5 for erases and lock clear, 4 for program and lock set. No start is issued, and the supply check takes priority over the lock check.
- R9: The sequence 30h then D0h starts a chip erase (`op_kind_o`=1). Its mask is all ones if `wp_i` is high, and the complement of `lock_o` if `wp_i` is low; a chip erase raises no lock error. A B0h during a chip erase is ignored.
- R10: While an operation runs and is not suspended, every byte except B0h is ignored, and `rd_sel_o` stays at 3.
- R11: A B0h during a block erase sets `hold_o[0]` and status bit 6, and status bit 7 reads 1. In that state only FFh, 40h/10h, 70h and D0h (resume) are accepted; other bytes are ignored.
- R12: A B0h during a program sets `hold_o[1]` and status bit 2. In that state only FFh, 70h and D0h are accepted. D0h resumes the innermost suspension. A D0h that arrives while a program started inside an erase suspend is still running is ignored, so the erase resumes only after that program is done.
- R13: The byte 50h clears bits 5, 4, 3 and 1 only when no operation is running or suspended. At any other time it is ignored.
- R14: The sequence B8h followed by 00h to 03h sets `sts_mode_o` to that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset; aborts operations |
| we_i | input | 1 | Host write enable, synchronous; command taken on its rising edge |
| data_i | input | 8 | Command or data byte |
| blk_i | input | BLK_W | Block index of the write |
| wp_i | input | 1 | Protect pin; high overrides lock bits |
| vpp_ok_i | input | 1 | Programming supply is in range |
| done_i | input | 1 | Engine reports end of the running operation |
| rd_sel_o | output | 2 | Read path: 0 array, 1 identifier, 2 query, 3 status |
| status_o | output | 8 | Status byte |
| sts_mode_o | output | 2 | Ready pin mode |
| lock_o | output | NBLK | Lock image |
| hold_o | output | 2 | Bit 0 erase held, bit 1 program held |
| op_start_o | output | 1 | One-cycle start request |
| op_kind_o | output | 3 | 0 block erase, 1 chip erase, 2 program, 3 lock set, 4 lock clear |
| op_blk_o | output | BLK_W | Target block |
| op_data_o | output | 8 | Program data |
| op_mask_o | output | NBLK | Blocks to erase |

## Verification
The assertions take four things for granted about the inputs:
- `done_i` pulses only while an operation is running and not suspended.
- `done_i` never coincides with a rising edge of `we_i`.
- `we_i` drops between commands.
- `wp_i` and `vpp_ok_i` are stable around each confirm edge.

The stimulus meets these assumptions by construction. It sends every command through a task that raises `we_i` for one cycle. It returns `done_i` only after a start pulse has been seen and the engine is not held. It changes the protect and supply inputs only between commands.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [1:0] {RD_ARRAY = 2'd0, RD_IDENT = 2'd1, RD_QUERY = 2'd2, RD_STATUS = 2'd3} rd_sel_e;
  typedef enum logic [2:0] {OP_BERASE = 3'd0, OP_CERASE = 3'd1, OP_PROG = 3'd2,
                            OP_LSET = 3'd3, OP_LCLR = 3'd4} op_kind_e;
  typedef enum logic [3:0] {C_ARRAY, C_IDENT, C_QUERY, C_STATUS, C_CLR, C_SUSP, C_RESUME,
                            C_BERASE, C_CERASE, C_PROG, C_LOCK, C_CFG} cmd_e;
  typedef enum logic [2:0] {P_NONE, P_BERASE, P_CERASE, P_PROG, P_LOCK, P_CFG} pend_e;
  localparam logic [7:0] K_GO   = 8'hD0;
  localparam logic [7:0] K_LSET = 8'h01;
endpackage

// File: rtl/fcd_classify.sv
module fcd_classify
  import flash_cmd_pkg::*;
(
  input  logic [7:0] code_i,
  output cmd_e       cmd_o
);
  always_comb begin
    unique case (code_i)
      8'h90:        cmd_o = C_IDENT;
      8'h98:        cmd_o = C_QUERY;
      8'h70:        cmd_o = C_STATUS;
      8'h50:        cmd_o = C_CLR;
      8'hB0:        cmd_o = C_SUSP;
      8'hD0:        cmd_o = C_RESUME;
      8'h20:        cmd_o = C_BERASE;
      8'h30:        cmd_o = C_CERASE;
      8'h40, 8'h10: cmd_o = C_PROG;
      8'h60:        cmd_o = C_LOCK;
      8'hB8:        cmd_o = C_CFG;
      default:      cmd_o = C_ARRAY;  // FFh and undefined bytes
    endcase
  end
endmodule

// File: rtl/fcd_lock_bank.sv
module fcd_lock_bank #(
  parameter int NBLK  = 32,
  parameter int BLK_W = $clog2(NBLK)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [BLK_W-1:0] set_blk_i,
  input  logic [BLK_W-1:0] chk_blk_i,
  output logic             locked_o,
  output logic [NBLK-1:0]  lock_o
);
  for (genvar g = 0; g < NBLK; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   lock_o[g] <= 1'b0;
      else if (clr_i)                                lock_o[g] <= 1'b0;
      else if (set_i && set_blk_i == BLK_W'(g))      lock_o[g] <= 1'b1;
    end
  end
  assign locked_o = lock_o[chk_blk_i];
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int NBLK  = 32,
  parameter int BLK_W = $clog2(NBLK)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [7:0]       data_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic             wp_i,
  input  logic             vpp_ok_i,
  input  logic             done_i,
  output logic [1:0]       rd_sel_o,
  output logic [7:0]       status_o,
  output logic [1:0]       sts_mode_o,
  output logic [NBLK-1:0]  lock_o,
  output logic [1:0]       hold_o,
  output logic             op_start_o,
  output logic [2:0]       op_kind_o,
  output logic [BLK_W-1:0] op_blk_o,
  output logic [7:0]       op_data_o,
  output logic [NBLK-1:0]  op_mask_o
);
  localparam logic [NBLK-1:0] ONE = {{(NBLK-1){1'b0}}, 1'b1};

  logic       we_q, start_q;
  rd_sel_e    rd_q;
  pend_e      pend_q;
  op_kind_e   kind_q;
  logic [1:0] sts_q;
  logic       e_erase, e_prog, e_vpp, e_lock;
  logic       er_act, er_chip, er_susp, pg_act, pg_susp, lk_act, lk_clr;
  logic [BLK_W-1:0] blk_q;
  logic [7:0]       data_q;
  logic [NBLK-1:0]  mask_q;

  cmd_e cmd;
  logic blk_locked;
  logic acc, busy, vpp_bad, prot_bad;

  fcd_classify u_cls (.code_i(data_i), .cmd_o(cmd));

  fcd_lock_bank #(.NBLK(NBLK), .BLK_W(BLK_W)) u_lock (
    .clk_i, .rst_ni,
    .set_i    (done_i & lk_act & ~lk_clr),
    .clr_i    (done_i & lk_act & lk_clr),
    .set_blk_i(blk_q),
    .chk_blk_i(blk_i),
    .locked_o (blk_locked),
    .lock_o   (lock_o)
  );

  assign acc      = we_i & ~we_q;
  assign busy     = (pg_act & ~pg_susp) | (er_act & ~er_susp) | lk_act;
  assign vpp_bad  = ~vpp_ok_i;
  assign prot_bad = blk_locked & ~wp_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q <= 1'b0; start_q <= 1'b0; rd_q <= RD_ARRAY; pend_q <= P_NONE;
      kind_q <= OP_BERASE; sts_q <= 2'd0;
      e_erase <= 1'b0; e_prog <= 1'b0; e_vpp <= 1'b0; e_lock <= 1'b0;
      er_act <= 1'b0; er_chip <= 1'b0; er_susp <= 1'b0;
      pg_act <= 1'b0; pg_susp <= 1'b0; lk_act <= 1'b0; lk_clr <= 1'b0;
      blk_q <= '0; data_q <= '0; mask_q <= '0;
    end else begin
      we_q    <= we_i;
      start_q <= 1'b0;
      if (done_i) begin
        if (pg_act && !pg_susp)      pg_act <= 1'b0;
        else if (er_act && !er_susp) er_act <= 1'b0;
        else if (lk_act)             lk_act <= 1'b0;
      end
      if (acc) begin
        if (pend_q != P_NONE) begin
          // second cycle of a two-cycle command
          pend_q <= P_NONE;
          rd_q   <= RD_STATUS;
          unique case (pend_q)
            P_BERASE, P_CERASE: begin
              if (data_i != K_GO) begin e_erase <= 1'b1; e_prog <= 1'b1; end
              else if (vpp_bad) begin e_vpp <= 1'b1; e_erase <= 1'b1; end
              else if (pend_q == P_BERASE && prot_bad) begin e_lock <= 1'b1; e_erase <= 1'b1; end
              else begin
                er_act <= 1'b1; er_chip <= (pend_q == P_CERASE); start_q <= 1'b1;
                blk_q  <= blk_i;
                kind_q <= (pend_q == P_CERASE) ? OP_CERASE : OP_BERASE;
                mask_q <= (pend_q == P_CERASE) ? (wp_i ? '1 : ~lock_o) : (ONE << blk_i);
              end
            end
            P_PROG: begin
              if (vpp_bad)       begin e_vpp <= 1'b1; e_prog <= 1'b1; end
              else if (prot_bad) begin e_lock <= 1'b1; e_prog <= 1'b1; end
              else begin
                pg_act <= 1'b1; start_q <= 1'b1; kind_q <= OP_PROG;
                blk_q <= blk_i; data_q <= data_i; mask_q <= '0;
              end
            end
            P_LOCK: begin
              if (data_i == K_LSET) begin
                if (vpp_bad) begin e_vpp <= 1'b1; e_prog <= 1'b1; end
                else begin
                  lk_act <= 1'b1; lk_clr <= 1'b0; start_q <= 1'b1;
                  kind_q <= OP_LSET; blk_q <= blk_i; mask_q <= '0;
                end
              end else if (data_i == K_GO) begin
                if (vpp_bad)    begin e_vpp <= 1'b1; e_erase <= 1'b1; end
                else if (!wp_i) begin e_lock <= 1'b1; e_erase <= 1'b1; end
                else begin
                  lk_act <= 1'b1; lk_clr <= 1'b1; start_q <= 1'b1;
                  kind_q <= OP_LCLR; mask_q <= '0;
                end
              end else begin e_erase <= 1'b1; e_prog <= 1'b1; end
            end
            P_CFG: begin
              if (data_i[7:2] == 6'd0) sts_q <= data_i[1:0];
              else begin e_erase <= 1'b1; e_prog <= 1'b1; end
            end
            default: ;
          endcase
        end else if (busy) begin
          if (cmd == C_SUSP) begin
            if (pg_act && !pg_susp) begin pg_susp <= 1'b1; rd_q <= RD_STATUS; end
            else if (er_act && !er_susp && !er_chip) begin er_susp <= 1'b1; rd_q <= RD_STATUS; end
          end
        end else if (pg_susp) begin
          unique case (cmd)
            C_ARRAY:  rd_q <= RD_ARRAY;
            C_STATUS: rd_q <= RD_STATUS;
            C_RESUME: begin pg_susp <= 1'b0; rd_q <= RD_STATUS; end
            default: ;
          endcase
        end else if (er_susp) begin
          unique case (cmd)
            C_ARRAY:  rd_q <= RD_ARRAY;
            C_STATUS: rd_q <= RD_STATUS;
            C_PROG:   begin pend_q <= P_PROG; rd_q <= RD_STATUS; end
            C_RESUME: begin er_susp <= 1'b0; rd_q <= RD_STATUS; end
            default: ;
          endcase
        end else begin
          unique case (cmd)
            C_ARRAY:  rd_q <= RD_ARRAY;
            C_IDENT:  rd_q <= RD_IDENT;
            C_QUERY:  rd_q <= RD_QUERY;
            C_STATUS: rd_q <= RD_STATUS;
            C_CLR:    begin e_erase <= 1'b0; e_prog <= 1'b0; e_vpp <= 1'b0; e_lock <= 1'b0; end
            C_BERASE: begin pend_q <= P_BERASE; rd_q <= RD_STATUS; end
            C_CERASE: begin pend_q <= P_CERASE; rd_q <= RD_STATUS; end
            C_PROG:   begin pend_q <= P_PROG;   rd_q <= RD_STATUS; end
            C_LOCK:   begin pend_q <= P_LOCK;   rd_q <= RD_STATUS; end
            C_CFG:    begin pend_q <= P_CFG;    rd_q <= RD_STATUS; end
            default: ;
          endcase
        end
      end
    end
  end

  assign rd_sel_o   = rd_q;
  assign status_o   = {~busy, er_susp, e_erase, e_prog, e_vpp, pg_susp, e_lock, 1'b0};
  assign sts_mode_o = sts_q;
  assign hold_o     = {pg_susp, er_susp};
  assign op_start_o = start_q;
  assign op_kind_o  = kind_q;
  assign op_blk_o   = blk_q;
  assign op_data_o  = data_q;
  assign op_mask_o  = mask_q;
endmodule

// File: rtl/fcd_checker.sv
module fcd_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wp_i,
  input logic       vpp_ok_i,
  input logic       op_start_o,
  input logic [1:0] rd_sel_o,
  input logic [7:0] status_o,
  input logic [1:0] hold_o
);
  a_r3_start_reads_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_start_o |-> rd_sel_o == 2'd3);

  a_r3_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_start_o |-> !status_o[7]);

  a_r11_suspend_from_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_o[0]) |-> !$past(status_o[7]));

  a_r12_erase_resume_after_prog: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hold_o[0]) |-> !$past(hold_o[1]) && $past(status_o[7]));

  a_r13_clear_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_o[5]) |-> $past(status_o[7]) && $past(hold_o) == 2'b00);

  a_r7_lock_err_needs_wp_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[1]) |-> !$past(wp_i));

  a_r8_vpp_err_needs_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[3]) |-> !$past(vpp_ok_i));
endmodule

bind flash_cmd_decoder fcd_checker u_chk (
  .clk_i, .rst_ni, .wp_i, .vpp_ok_i, .op_start_o, .rd_sel_o, .status_o, .hold_o
);

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int NBLK = 32;
  localparam int BLK_W = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic we = 1'b0, wp = 1'b1, vpp = 1'b1, done = 1'b0;
  logic [7:0] data = 8'h00;
  logic [BLK_W-1:0] blk = '0;
  logic [1:0] rd_sel, sts_mode, hold;
  logic [7:0] status, op_data;
  logic [NBLK-1:0] lock, mask;
  logic op_start;
  logic [2:0] kind;
  logic [BLK_W-1:0] op_blk;

  int checks = 0, failures = 0, cycles = 0;
  logic [NBLK-1:0] lk_model;
  int unsigned r_sel, r_k;
  logic [7:0] r_code, r_data;
  logic [BLK_W-1:0] r_blk;
  logic r_wp, r_vpp, r_go;

  flash_cmd_decoder #(.NBLK(NBLK), .BLK_W(BLK_W)) uut (
    .clk_i(clk), .rst_ni, .we_i(we), .data_i(data), .blk_i(blk), .wp_i(wp),
    .vpp_ok_i(vpp), .done_i(done), .rd_sel_o(rd_sel), .status_o(status),
    .sts_mode_o(sts_mode), .lock_o(lock), .hold_o(hold), .op_start_o(op_start),
    .op_kind_o(kind), .op_blk_o(op_blk), .op_data_o(op_data), .op_mask_o(mask)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      failures = failures + 1;
      $display("FAIL watchdog act=%0d exp=<100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic [BLK_W-1:0] b);
    @(negedge clk); data = d; blk = b; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic eng_done();
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
  endtask

  function automatic logic [1:0] exp_mode(input logic [7:0] c);
    case (c)
      8'h90: return 2'd1;
      8'h98: return 2'd2;
      8'h70: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic bit is_cmd(input logic [7:0] c);
    return c inside {8'h90, 8'h98, 8'h70, 8'h50, 8'hB0, 8'hD0, 8'h20, 8'h30,
                     8'h40, 8'h10, 8'h60, 8'hB8};
  endfunction

  initial begin
    r_k = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rd_sel", 32'(rd_sel), 0);
    chk("R1 status", 32'(status), 32'h80);
    chk("R1 hold", 32'(hold), 0);
    chk("R1 lock", lock, 0);
    chk("R1 sts_mode", 32'(sts_mode), 0);
    chk("R1 start", 32'(op_start), 0);

    // R2 read modes
    wr(8'h90, 0); chk("R2 ident", 32'(rd_sel), 1);
    wr(8'h98, 0); chk("R2 query", 32'(rd_sel), 2);
    wr(8'h70, 0); chk("R2 status", 32'(rd_sel), 3);
    wr(8'h5A, 0); chk("R2 undefined", 32'(rd_sel), 0);
    // R2 held write enable delivers one command: 20h held, then D0h confirms
    @(negedge clk); data = 8'h20; blk = 5'd2; we = 1'b1;
    repeat (3) @(negedge clk);
    we = 1'b0;
    wr(8'hD0, 5'd2);
    chk("R2 single take", 32'(op_start), 1);
    chk("R2 no seq err", 32'(status), 32'h00);
    eng_done();

    // R3 block erase
    wr(8'h20, 5'd5); wr(8'hD0, 5'd5);
    chk("R3 start", 32'(op_start), 1);
    chk("R3 kind", 32'(kind), 0);
    chk("R3 blk", 32'(op_blk), 5);
    chk("R3 mask", mask, 32'h20);
    chk("R3 rd", 32'(rd_sel), 3);
    chk("R3 busy", 32'(status), 32'h00);
    // R10 busy ignores
    wr(8'hFF, 0); chk("R10 array ignored", 32'(rd_sel), 3);
    // R11 erase suspend
    wr(8'hB0, 0);
    chk("R11 hold", 32'(hold), 1);
    chk("R11 status", 32'(status), 32'hC0);
    wr(8'h90, 0); chk("R11 ident ignored", 32'(rd_sel), 3);
    wr(8'hFF, 0); chk("R11 array", 32'(rd_sel), 0);
    wr(8'h70, 0); chk("R11 status rd", 32'(rd_sel), 3);
    // R4 program during erase suspend
    wr(8'h40, 5'd7); wr(8'hA5, 5'd7);
    chk("R4 start", 32'(op_start), 1);
    chk("R4 kind", 32'(kind), 2);
    chk("R4 data", 32'(op_data), 32'hA5);
    chk("R4 blk", 32'(op_blk), 7);
    chk("R4 status", 32'(status), 32'h40);
    // R12 nesting
    wr(8'hD0, 0); chk("R12 resume ignored while prog runs", 32'(hold), 1);
    wr(8'hB0, 0);
    chk("R12 hold", 32'(hold), 3);
    chk("R12 status", 32'(status), 32'hC4);
    wr(8'h90, 0); chk("R12 ident ignored", 32'(rd_sel), 3);
    wr(8'hFF, 0); chk("R12 array", 32'(rd_sel), 0);
    wr(8'hD0, 0); chk("R12 prog resumed", 32'(status), 32'h40);
    eng_done();   chk("R12 back in erase suspend", 32'(status), 32'hC0);
    wr(8'hD0, 0); chk("R12 erase resumed", 32'(status), 32'h00);
    eng_done();   chk("R12 idle", 32'(status), 32'h80);

    // R5 sequence error
    wr(8'h20, 5'd1); wr(8'h33, 5'd1);
    chk("R5 no start", 32'(op_start), 0);
    chk("R5 status", 32'(status), 32'hB0);
    wr(8'h50, 0); chk("R13 cleared", 32'(status), 32'h80);

    // R6 lock set
    wr(8'h60, 5'd3); wr(8'h01, 5'd3);
    chk("R6 start", 32'(op_start), 1);
    chk("R6 kind set", 32'(kind), 3);
    eng_done();
    chk("R6 lock bit", lock, 32'h8);

    // R7 protection
    wp = 1'b0;
    wr(8'h20, 5'd3); wr(8'hD0, 5'd3);
    chk("R7 erase no start", 32'(op_start), 0);
    chk("R7 erase err", 32'(status), 32'hA2);
    wr(8'h50, 0);
    wr(8'h10, 5'd3); wr(8'h11, 5'd3);
    chk("R7 prog err", 32'(status), 32'h92);
    wr(8'h50, 0);
    wp = 1'b1;
    wr(8'h40, 5'd3); wr(8'h3C, 5'd3);
    chk("R7 prog with wp high", 32'(op_start), 1);
    eng_done();

    // R8 supply low, priority over lock
    vpp = 1'b0; wp = 1'b0;
    wr(8'h20, 5'd3); wr(8'hD0, 5'd3);
    chk("R8 no start", 32'(op_start), 0);
    chk("R8 status", 32'(status), 32'hA8);
    wr(8'h50, 0);
    vpp = 1'b1;

    // R9 chip erase
    wr(8'h30, 0); wr(8'hD0, 0);
    chk("R9 start", 32'(op_start), 1);
    chk("R9 kind", 32'(kind), 1);
    chk("R9 mask skips locked", mask, 32'hFFFF_FFF7);
    chk("R9 no lock err", 32'(status), 32'h00);
    wr(8'hB0, 0); chk("R9 suspend ignored", 32'(hold), 0);
    eng_done();
    wp = 1'b1;
    wr(8'h30, 0); wr(8'hD0, 0);
    chk("R9 mask all", mask, 32'hFFFF_FFFF);
    eng_done();

    // R6 clear needs wp
    wp = 1'b0;
    wr(8'h60, 0); wr(8'hD0, 0);
    chk("R6 clear refused", 32'(status), 32'hA2);
    chk("R6 locks kept", lock, 32'h8);
    wp = 1'b1;
    // R13 clear ignored while running and suspended
    wr(8'h40, 5'd0); wr(8'h77, 5'd0);
    wr(8'h50, 0); chk("R13 ignored while busy", 32'(status[5:1]), 5'b10001);
    eng_done();
    wr(8'h20, 5'd0); wr(8'hD0, 5'd0); wr(8'hB0, 0);
    wr(8'h50, 0); chk("R13 ignored while suspended", 32'(status), 32'hE2);
    wr(8'hD0, 0); eng_done();
    wr(8'h50, 0); chk("R13 idle clear", 32'(status), 32'h80);
    wr(8'h60, 0); wr(8'hD0, 0);
    chk("R6 kind clear", 32'(kind), 4);
    eng_done();
    chk("R6 locks cleared", lock, 0);

    // R14 config
    wr(8'hB8, 0); wr(8'h02, 0);
    chk("R14 mode", 32'(sts_mode), 2);
    wr(8'hB8, 0); wr(8'h07, 0);
    chk("R14 bad value kept", 32'(sts_mode), 2);
    chk("R5 cfg seq err", 32'(status), 32'hB0);
    wr(8'h50, 0);

    // R1 reset aborts
    wr(8'h20, 5'd4); wr(8'hD0, 5'd4); wr(8'hB0, 0);
    @(negedge clk); rst_ni = 1'b0;
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 abort status", 32'(status), 32'h80);
    chk("R1 abort hold", 32'(hold), 0);
    chk("R1 abort rd", 32'(rd_sel), 0);
    chk("R1 abort mode", 32'(sts_mode), 0);

    // random phase
    lk_model = '0;
    for (int i = 0; i < 150; i++) begin
      r_sel = $urandom % 3;
      if (r_sel == 0) begin
        r_k = $urandom % 5;
        if (r_k == 0) r_code = 8'hFF;
        else if (r_k == 1) r_code = 8'h90;
        else if (r_k == 2) r_code = 8'h98;
        else if (r_k == 3) r_code = 8'h70;
        else begin
          r_code = 8'($urandom);
          while (is_cmd(r_code)) r_code = 8'($urandom);
        end
        wr(r_code, 0);
        chk("R2 random mode", 32'(rd_sel), 32'(exp_mode(r_code)));
      end else if (r_sel == 1) begin
        r_blk = BLK_W'($urandom);
        r_wp  = 1'($urandom);
        r_vpp = ($urandom % 4) != 0;
        r_data = 8'($urandom);
        wp = r_wp; vpp = r_vpp;
        wr((($urandom % 2) != 0) ? 8'h40 : 8'h10, r_blk);
        wr(r_data, r_blk);
        r_go = 1'b0;
        if (!r_vpp) chk("R8 random prog", 32'(status), 32'h98);
        else if (lk_model[r_blk] && !r_wp) chk("R7 random prog", 32'(status), 32'h92);
        else begin
          r_go = 1'b1;
          chk("R4 random start", 32'(op_start), 1);
          chk("R4 random data", 32'(op_data), 32'(r_data));
          chk("R4 random blk", 32'(op_blk), 32'(r_blk));
        end
        if (r_go) eng_done(); else wr(8'h50, 0);
        vpp = 1'b1; wp = 1'b1;
      end else begin
        if (($urandom % 4) == 0) begin
          wr(8'h60, 0); wr(8'hD0, 0);
          chk("R6 random clear kind", 32'(kind), 4);
          eng_done();
          lk_model = '0;
        end else begin
          r_blk = BLK_W'($urandom);
          wr(8'h60, r_blk); wr(8'h01, r_blk);
          chk("R6 random set kind", 32'(kind), 3);
          eng_done();
          lk_model[r_blk] = 1'b1;
        end
        chk("R6 random lock image", lock, lk_model);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule